// File: doc/BRIEF.md
# Adaptive Golomb Entropy Coder with Per-Band Statistics

This block is the high-entropy branch of a hybrid entropy coder for multi-band image data. It takes one unsigned mapped residual at a time, together with the band that residual belongs to. For each band it keeps a running sum of residuals and a sample count, and uses their ratio to decide whether the sample belongs to high-entropy or low-entropy coding. Samples that go to the low-entropy coder are only reported on the mode flag; this block does not code them.

For a high-entropy sample, the block searches for a Golomb power-of-two parameter from the same two statistics. It then writes a reversed, length-limited codeword into a byte packer. When the count reaches its limit, both statistics are halved, and the low bit of the sum is placed in the stream at that point.

The sample that carries the last flag ends the image. After it, the packer appends a terminating one and zero fill up to a byte boundary, and the final byte leaves with LAST set. Bytes are delivered on an AXI4-Stream style output with VALID, READY and LAST. Configuration is held static for the whole image: the limit on the unary part, the two count exponents, the sample depth and the starting sum.

Top module: `agc_coder`

## Requirements
- R1: After reset the output stream has no valid byte, the input is ready, and both the done flag and the mode strobe are low.
- R2: Each band keeps its own sum and count. The first sample of a band in an image starts from sum = cfg_acc_init and count = 2^cfg_gamma0. Every sample adds its residual to the sum and adds one to the count before the mode decision. Samples of one band never change another band's statistics.
- R3: If a band's count equals 2^cfg_gamma − 1 when a sample arrives, the low bit of (sum + residual) is emitted as one bit ahead of that sample's codeword. The new sum is then (sum + residual)/2 rounded down, and the new count is 2^(cfg_gamma−1).
- R4: Using the updated statistics, a sample is high-entropy when sum·2^14 ≥ T0·count (T0 = 303336 by default). mode_hi gives the decision, qualified by a one-cycle mode_vld pulse for each sample. A low-entropy sample emits no codeword bits.
- R5: k is the largest value in 0..cfg_depth−2 with count·2^k ≤ sum + floor(49·count/128), and 0 if no value qualifies.
- R6: With u = floor(residual/2^k) < cfg_umax, the codeword is the k low residual bits (most significant of them first), then a single 1, then u zeros.
- R7: With u ≥ cfg_umax, the codeword is the residual written in cfg_depth bits (most significant first), followed by cfg_umax zeros.
- R8: Stream bits are packed most significant first. The first bit of the stream is bit 7 of the first byte, and no bits are lost or reordered.
- R9: After the sample flagged last has been coded, a 1 and then zeros are appended up to the next byte boundary. When the stream is already aligned, this adds a whole 0x80 byte. out_tlast is high on the final byte only, and every band starts from fresh statistics in the next image.
- R10: While out_tvalid is high and out_tready is low, out_tvalid stays high and out_tdata holds its value.
- R11: done rises after the final byte of an image has been accepted. It stays high until the next sample is accepted, then falls.
- R12: in_ready is low from the cycle after a sample is accepted until that sample has been fully coded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_umax | input | 6 | Limit on the unary part, 8..32 |
| cfg_gamma | input | 4 | Exponent of the count that triggers halving, max(4, cfg_gamma0+1)..9 |
| cfg_gamma0 | input | 4 | Exponent of the starting count, 1..8 |
| cfg_depth | input | 5 | Sample depth D in bits, 2..16 |
| cfg_acc_init | input | 26 | Starting sum for each band |
| in_valid | input | 1 | Residual present |
| in_ready | output | 1 | Residual accepted when high together with in_valid |
| in_resid | input | 16 | Unsigned mapped residual, fits in cfg_depth bits |
| in_band | input | 2 | Band index of the residual |
| in_last | input | 1 | Residual is the final one of the image |
| out_tdata | output | 8 | Output byte |
| out_tvalid | output | 1 | Output byte valid |
| out_tready | input | 1 | Downstream accepts the byte |
| out_tlast | output | 1 | Final byte of the image |
| mode_vld | output | 1 | One-cycle strobe qualifying mode_hi |
| mode_hi | output | 1 | 1 = high-entropy sample, 0 = low-entropy sample |
| done | output | 1 | Image fully emitted |

## Verification
The bench targets the corner cases this coder is most likely to get wrong.

- Halving: it drives a band to the count limit so that halving happens. A design that read the count after incrementing, or that dropped the low bit, would misplace or lose one stream bit, and every later byte would shift.
- Escape codeword: a residual far above the band's running mean forces the escape form. Using the unary form there, or the wrong depth, gives bytes other than 03 E8 00 80.
- Padding: an image with no emitted bits must give exactly one 0x80 byte. A coder that skips padding when the stream is already aligned would produce an empty stream.
- Restart and backpressure: reusing a band across images catches statistics that are not restarted. Random READY stalls catch output bytes that change while held.

// File: rtl/agc_pkg.sv
package agc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // width of the bit packer window and of a staged codeword
  localparam int unsigned PK_BITS = 64;
  localparam int unsigned PK_CW   = $clog2(PK_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UPD,
    ST_KSRCH,
    ST_EMIT,
    ST_PAD,
    ST_DRAIN
  } agc_state_e;
endpackage

// File: rtl/agc_stats.sv
module agc_stats #(
  parameter int unsigned NB = 4,
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 26,
  parameter int unsigned CW = 10,
  parameter int unsigned T0 = 303336,
  localparam int unsigned BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] rd_band,
  input  logic [DW-1:0] resid,
  input  logic          upd_en,
  input  logic          clr_all,
  input  logic [3:0]    cfg_gamma,
  input  logic [3:0]    cfg_gamma0,
  input  logic [AW-1:0] cfg_acc_init,
  output logic [AW-1:0] new_acc,
  output logic [CW-1:0] new_cnt,
  output logic          resc,
  output logic          resc_bit,
  output logic          hi
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [AW-1:0] acc_q   [NB];
  logic [CW-1:0] cnt_q   [NB];
  logic [NB-1:0] fresh_q;

  logic [AW-1:0] cur_acc, sum;
  logic [CW-1:0] cur_cnt, lim;
  logic [63:0]   lhs, rhs;

  always_comb begin
    cur_acc  = fresh_q[rd_band] ? cfg_acc_init : acc_q[rd_band];
    cur_cnt  = fresh_q[rd_band] ? (CW'(1) << cfg_gamma0) : cnt_q[rd_band];
    lim      = (CW'(1) << cfg_gamma) - CW'(1);
    sum      = cur_acc + AW'(resid);
    resc     = (cur_cnt == lim);
    resc_bit = sum[0];
    new_acc  = resc ? (sum >> 1) : sum;
    new_cnt  = resc ? ((cur_cnt + CW'(1)) >> 1) : (cur_cnt + CW'(1));
    lhs      = 64'(new_acc) << 14;
    rhs      = 64'(T0) * 64'(new_cnt);
    hi       = (lhs >= rhs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        acc_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      fresh_q <= '1;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (clr_all) begin
          fresh_q[i] <= 1'b1;
        end else if (upd_en && (rd_band == BW'(i))) begin
          acc_q[i]   <= new_acc;
          cnt_q[i]   <= new_cnt;
          fresh_q[i] <= 1'b0;
        end
      end
    end
  end

  // R3
  halve_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && resc) |-> (new_cnt == (CW'(1) << (cfg_gamma - 4'd1))));
endmodule

// File: rtl/agc_kfind.sv
module agc_kfind #(
  parameter int unsigned AW = 26,
  parameter int unsigned CW = 10,
  parameter int unsigned KW = 4,
  parameter int unsigned DPW = 5
) (
  input  logic [AW-1:0]  acc,
  input  logic [CW-1:0]  cnt,
  input  logic [KW-1:0]  k,
  input  logic [DPW-1:0] depth,
  output logic           step_ok
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [KW:0]  kn;
  logic [63:0]  lhs, rhs;

  // one step of the search: may k grow by one?
  always_comb begin
    kn      = {1'b0, k} + (KW+1)'(1);
    rhs     = 64'(acc) + ((64'(cnt) * 64'd49) >> 7);
    lhs     = 64'(cnt) << kn;
    step_ok = ((7'(kn) + 7'd2) <= 7'(depth)) && (lhs <= rhs);
  end
endmodule

// File: rtl/agc_cwgen.sv
module agc_cwgen
  import agc_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned KW = 4,
  parameter int unsigned DPW = 5
) (
  input  logic [DW-1:0]    resid,
  input  logic [KW-1:0]    k,
  input  logic [5:0]       umax,
  input  logic [DPW-1:0]   depth,
  input  logic             is_hi,
  input  logic             resc,
  input  logic             rbit,
  output logic [PK_BITS-1:0] cw,
  output logic [PK_CW-1:0]   len
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DW-1:0]      u, lowbits;
  logic               esc;
  logic [PK_BITS-1:0] body, nbody, ebody;
  logic [PK_CW-1:0]   blen, nlen, elen;

  always_comb begin
    u       = resid >> k;
    esc     = (u >= DW'(umax));
    lowbits = resid & ((DW'(1) << k) - DW'(1));
    // k low bits then a one, left aligned in the window
    nbody   = ((PK_BITS'(lowbits) << 1) | PK_BITS'(1)) << (PK_CW'(PK_BITS - 1) - PK_CW'(k));
    nlen    = PK_CW'(k) + PK_CW'(1) + PK_CW'(u);
    ebody   = PK_BITS'(resid) << (PK_CW'(PK_BITS) - PK_CW'(depth));
    elen    = PK_CW'(depth) + PK_CW'(umax);
    if (!is_hi) begin
      body = '0;
      blen = '0;
    end else if (esc) begin
      body = ebody;
      blen = elen;
    end else begin
      body = nbody;
      blen = nlen;
    end
    if (resc) begin
      cw  = {rbit, body[PK_BITS-1:1]};
      len = blen + PK_CW'(1);
    end else begin
      cw  = body;
      len = blen;
    end
  end
endmodule

// File: rtl/agc_packer.sv
module agc_packer
  import agc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               app_en,
  input  logic               app_flush,
  input  logic [PK_BITS-1:0] app_cw,
  input  logic [PK_CW-1:0]   app_len,
  output logic [PK_CW-1:0]   fill,
  output logic [7:0]         out_tdata,
  output logic               out_tvalid,
  input  logic               out_tready,
  output logic               out_tlast
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [PK_BITS-1:0] pbuf_q, pbuf_d, merged;
  logic [PK_CW-1:0]   pcnt_q, pcnt_d, mcnt;
  logic               lastp_q, lastp_d, pop;

  assign fill       = pcnt_q;
  assign out_tvalid = (pcnt_q >= PK_CW'(8));
  assign out_tdata  = pbuf_q[PK_BITS-1 -: 8];
  assign out_tlast  = lastp_q && (pcnt_q == PK_CW'(8));
  assign pop        = out_tvalid && out_tready;

  always_comb begin
    merged  = app_en ? (pbuf_q | (app_cw >> pcnt_q)) : pbuf_q;
    mcnt    = app_en ? (pcnt_q + app_len) : pcnt_q;
    pbuf_d  = pop ? (merged << 8) : merged;
    pcnt_d  = pop ? (mcnt - PK_CW'(8)) : mcnt;
    lastp_d = lastp_q;
    if (app_en && app_flush) lastp_d = 1'b1;
    else if (pop && out_tlast) lastp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbuf_q  <= '0;
      pcnt_q  <= '0;
      lastp_q <= 1'b0;
    end else begin
      pbuf_q  <= pbuf_d;
      pcnt_q  <= pcnt_d;
      lastp_q <= lastp_d;
    end
  end

  // R10
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && !out_tready) |=> (out_tvalid && $stable(out_tdata)));

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PK_CW'(PK_BITS));
endmodule

// File: rtl/agc_coder.sv
module agc_coder
  import agc_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned DW = 16,
  parameter int unsigned T0 = 303336,
  localparam int unsigned BW  = $clog2(NB),
  localparam int unsigned AW  = DW + 10,
  localparam int unsigned CW  = 10,
  localparam int unsigned KW  = $clog2(DW),
  localparam int unsigned DPW = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [5:0]     cfg_umax,
  input  logic [3:0]     cfg_gamma,
  input  logic [3:0]     cfg_gamma0,
  input  logic [DPW-1:0] cfg_depth,
  input  logic [AW-1:0]  cfg_acc_init,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_resid,
  input  logic [BW-1:0]  in_band,
  input  logic           in_last,
  output logic [7:0]     out_tdata,
  output logic           out_tvalid,
  input  logic           out_tready,
  output logic           out_tlast,
  output logic           mode_vld,
  output logic           mode_hi,
  output logic           done
);
  timeunit 1ns;
  timeprecision 1ps;

  agc_state_e st_q, st_d;
  logic [DW-1:0] r_q, r_d;
  logic [BW-1:0] b_q, b_d;
  logic          last_q, last_d, done_q, done_d;
  logic [AW-1:0] acc_l, acc_d;
  logic [CW-1:0] cnt_l, cnt_d;
  logic          resc_l, resc_d, rbit_l, rbit_d, hi_l, hi_d;
  logic [KW-1:0] k_q, k_d;
  logic          mv_q, mv_d, mh_q, mh_d;

  logic [AW-1:0] new_acc;
  logic [CW-1:0] new_cnt;
  logic          new_resc, new_rbit, new_hi, step_ok;
  logic          upd_en, clr_all, app_en, app_pad, room;
  logic [PK_BITS-1:0] gen_cw, app_cw;
  logic [PK_CW-1:0]   gen_len, app_len, pad_len, fill;

  agc_stats #(.NB(NB), .DW(DW), .AW(AW), .CW(CW), .T0(T0)) u_stats (
    .clk, .rst_n, .rd_band(b_q), .resid(r_q), .upd_en, .clr_all,
    .cfg_gamma, .cfg_gamma0, .cfg_acc_init,
    .new_acc, .new_cnt, .resc(new_resc), .resc_bit(new_rbit), .hi(new_hi));

  agc_kfind #(.AW(AW), .CW(CW), .KW(KW), .DPW(DPW)) u_kfind (
    .acc(acc_l), .cnt(cnt_l), .k(k_q), .depth(cfg_depth), .step_ok);

  agc_cwgen #(.DW(DW), .KW(KW), .DPW(DPW)) u_cwgen (
    .resid(r_q), .k(k_q), .umax(cfg_umax), .depth(cfg_depth),
    .is_hi(hi_l), .resc(resc_l), .rbit(rbit_l), .cw(gen_cw), .len(gen_len));

  agc_packer u_pack (
    .clk, .rst_n, .app_en, .app_flush(app_pad), .app_cw, .app_len, .fill,
    .out_tdata, .out_tvalid, .out_tready, .out_tlast);

  assign in_ready = (st_q == ST_IDLE);
  assign mode_vld = mv_q;
  assign mode_hi  = mh_q;
  assign done     = done_q;
  assign pad_len  = (fill[2:0] == 3'd0) ? PK_CW'(8) : (PK_CW'(8) - PK_CW'(fill[2:0]));
  assign app_cw   = app_pad ? {1'b1, {(PK_BITS-1){1'b0}}} : gen_cw;
  assign app_len  = app_pad ? pad_len : gen_len;
  assign room     = ({1'b0, fill} + {1'b0, app_len}) <= (PK_CW+1)'(PK_BITS);

  always_comb begin
    st_d = st_q;   r_d = r_q;     b_d = b_q;       last_d = last_q;
    done_d = done_q; acc_d = acc_l; cnt_d = cnt_l; resc_d = resc_l;
    rbit_d = rbit_l; hi_d = hi_l;  k_d = k_q;      mv_d = 1'b0;  mh_d = mh_q;
    upd_en = 1'b0; clr_all = 1'b0; app_en = 1'b0;  app_pad = 1'b0;
    case (st_q)
      ST_IDLE: if (in_valid) begin
        r_d = in_resid; b_d = in_band; last_d = in_last; done_d = 1'b0;
        st_d = ST_UPD;
      end
      ST_UPD: begin
        upd_en = 1'b1;
        acc_d = new_acc; cnt_d = new_cnt; resc_d = new_resc; rbit_d = new_rbit;
        hi_d = new_hi; k_d = '0; mv_d = 1'b1; mh_d = new_hi;
        st_d = new_hi ? ST_KSRCH : ST_EMIT;
      end
      ST_KSRCH: begin
        if (step_ok) k_d = k_q + KW'(1);
        else         st_d = ST_EMIT;
      end
      ST_EMIT: begin
        if (gen_len == '0) begin
          st_d = last_q ? ST_PAD : ST_IDLE;
        end else if (room) begin
          app_en = 1'b1;
          st_d   = last_q ? ST_PAD : ST_IDLE;
        end
      end
      ST_PAD: begin
        app_pad = 1'b1;
        if (room) begin
          app_en = 1'b1; clr_all = 1'b1; st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: if (fill == '0) begin
        done_d = 1'b1; st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; r_q <= '0; b_q <= '0; last_q <= 1'b0; done_q <= 1'b0;
      acc_l <= '0; cnt_l <= '0; resc_l <= 1'b0; rbit_l <= 1'b0; hi_l <= 1'b0;
      k_q <= '0; mv_q <= 1'b0; mh_q <= 1'b0;
    end else begin
      st_q <= st_d; r_q <= r_d; b_q <= b_d; last_q <= last_d; done_q <= done_d;
      acc_l <= acc_d; cnt_l <= cnt_d; resc_l <= resc_d; rbit_l <= rbit_d; hi_l <= hi_d;
      k_q <= k_d; mv_q <= mv_d; mh_q <= mh_d;
    end
  end

  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R5
  k_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EMIT && hi_l) |-> ((7'(k_q) + 7'd2) <= 7'(cfg_depth)));

  // R11
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st_q == ST_DRAIN));

  // R4
  mode_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_vld |=> !mode_vld);
endmodule

// File: tb/tb_agc_coder.sv
module tb_agc_coder;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned T0V = 303336;
  localparam int NSTIM = 24;
  // entry = {last, band[1:0], residual[15:0]}
  localparam logic [18:0] STIM [NSTIM] = '{
    {1'b0,2'd0,16'd20},  {1'b0,2'd1,16'd255}, {1'b0,2'd0,16'd25}, {1'b0,2'd2,16'd0},
    {1'b0,2'd0,16'd3},   {1'b0,2'd3,16'd100}, {1'b0,2'd0,16'd40}, {1'b0,2'd1,16'd12},
    {1'b0,2'd0,16'd18},  {1'b0,2'd2,16'd0},   {1'b0,2'd0,16'd0},  {1'b0,2'd3,16'd7},
    {1'b0,2'd0,16'd0},   {1'b0,2'd0,16'd0},   {1'b0,2'd1,16'd30}, {1'b0,2'd0,16'd0},
    {1'b0,2'd0,16'd0},   {1'b0,2'd0,16'd0},   {1'b0,2'd3,16'd9},  {1'b0,2'd0,16'd1},
    {1'b0,2'd0,16'd30},  {1'b0,2'd0,16'd22},  {1'b0,2'd2,16'd1},  {1'b1,2'd0,16'd17}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [5:0]  c_umax;
  logic [3:0]  c_g, c_g0;
  logic [4:0]  c_d;
  logic [25:0] c_init;
  logic        in_valid, in_ready, in_last;
  logic [15:0] in_resid;
  logic [1:0]  in_band;
  logic [7:0]  out_tdata;
  logic        out_tvalid, out_tready, out_tlast;
  logic        mode_vld, mode_hi, done;

  int checks = 0, errors = 0, cyc = 0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  bit   exp_bits [0:2047];
  int   exp_n;
  logic [7:0] got_b [0:255];
  bit   got_l [0:255];
  int   got_n;
  bit   exp_mode [0:63];
  bit   got_mode [0:63];
  int   em_n, gm_n;
  longint m_acc [4];
  longint m_cnt [4];
  bit     m_fresh [4];
  bit     prev_stall = 1'b0;
  logic [7:0] prev_data;

  agc_coder dut (
    .clk, .rst_n, .cfg_umax(c_umax), .cfg_gamma(c_g), .cfg_gamma0(c_g0),
    .cfg_depth(c_d), .cfg_acc_init(c_init), .in_valid, .in_ready, .in_resid,
    .in_band, .in_last, .out_tdata, .out_tvalid, .out_tready, .out_tlast,
    .mode_vld, .mode_hi, .done);

  always #2 clk = ~clk;  // 250 MHz

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_tready = bp_on ? lfsr[0] : 1'b1;
  end

  // monitor, away from the active edge
  always @(negedge clk) if (rst_n) begin
    if (prev_stall) // R10
      check(out_tvalid && out_tdata == prev_data, "R10 hold", out_tdata, prev_data);
    prev_stall = out_tvalid && !out_tready;
    prev_data  = out_tdata;
    if (out_tvalid && out_tready) begin
      got_b[got_n] = out_tdata;
      got_l[got_n] = out_tlast;
      got_n++;
    end
    if (mode_vld) begin
      got_mode[gm_n] = mode_hi;
      gm_n++;
    end
  end

  task automatic push(bit b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  // expected behaviour written from the requirements
  task automatic m_sample(int b, int d);
    longint a, c, s;
    int k, u;
    bit hi;
    if (m_fresh[b]) begin
      m_acc[b] = c_init; m_cnt[b] = longint'(1) << c_g0; m_fresh[b] = 1'b0;
    end
    a = m_acc[b]; c = m_cnt[b];
    if (c == (longint'(1) << c_g) - 1) begin   // R3
      s = a + d; push(s[0]); a = s / 2; c = (c + 1) / 2;
    end else begin                              // R2
      a = a + d; c = c + 1;
    end
    m_acc[b] = a; m_cnt[b] = c;
    hi = (a * 16384 >= longint'(T0V) * c);      // R4
    exp_mode[em_n] = hi; em_n++;
    if (hi) begin
      k = 0;                                    // R5
      for (int kk = 0; kk <= int'(c_d) - 2; kk++)
        if ((c << kk) <= a + (49 * c) / 128) k = kk;
      u = d >> k;
      if (u < int'(c_umax)) begin               // R6
        for (int j = k - 1; j >= 0; j--) push(((d >> j) & 1) != 0);
        push(1'b1);
        for (int j = 0; j < u; j++) push(1'b0);
      end else begin                            // R7
        for (int j = int'(c_d) - 1; j >= 0; j--) push(((d >> j) & 1) != 0);
        for (int j = 0; j < int'(c_umax); j++) push(1'b0);
      end
    end
  endtask

  task automatic new_image();
    exp_n = 0; got_n = 0; em_n = 0; gm_n = 0;
    for (int i = 0; i < 4; i++) m_fresh[i] = 1'b1;
  endtask

  task automatic send(int d, int b, bit l, bit chk_busy);
    @(posedge clk); #1;
    in_valid = 1'b1; in_resid = 16'(d); in_band = 2'(b); in_last = l;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (chk_busy) begin
      check(in_ready == 1'b0, "R12 busy after accept", in_ready, 0);
      check(done == 1'b0, "R11 done clears on accept", done, 0);
    end
    m_sample(b, d);
  endtask

  task automatic finish_image(string tag);
    logic [7:0] eb;
    push(1'b1);                                 // R9
    while (exp_n % 8 != 0) push(1'b0);
    @(negedge clk);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R11 done holds", done, 1);
    check(got_n == exp_n / 8, {"R8 byte count ", tag}, got_n, exp_n / 8);
    for (int i = 0; i < got_n && i < exp_n / 8; i++) begin
      eb = '0;
      for (int j = 0; j < 8; j++) eb[7-j] = exp_bits[8*i + j];
      check(got_b[i] == eb, {"R2/R3/R5/R6/R7/R8 byte ", tag}, got_b[i], eb);
      check(got_l[i] == (i == got_n - 1), {"R9 tlast ", tag}, got_l[i], i == got_n - 1);
    end
    check(gm_n == em_n, {"R4 mode count ", tag}, gm_n, em_n);
    for (int i = 0; i < gm_n && i < em_n; i++)
      check(got_mode[i] == exp_mode[i], {"R4 mode ", tag}, got_mode[i], exp_mode[i]);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_resid = '0; in_band = '0; in_last = 1'b0;
    out_tready = 1'b1;
    c_umax = 6'd8; c_g = 4'd4; c_g0 = 4'd1; c_d = 5'd8; c_init = 26'd40;
    got_n = 0; gm_n = 0;
    repeat (3) @(negedge clk);
    // R1
    check(out_tvalid == 1'b0, "R1 tvalid", out_tvalid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(done == 1'b0, "R1 done", done, 0);
    check(mode_vld == 1'b0, "R1 mode_vld", mode_vld, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_tvalid == 1'b0 && in_ready == 1'b1, "R1 after release", out_tvalid, 0);

    // image A: table walk, mixed bands, halving in band 0, random stalls
    new_image();
    bp_on = 1'b1;
    for (int i = 0; i < NSTIM; i++)
      send(int'(STIM[i][15:0]), int'(STIM[i][17:16]), STIM[i][18], i == 0);
    finish_image("A");
    bp_on = 1'b0;

    // image B: nothing coded, aligned stream still gets a 0x80 byte; band 0 restarts
    c_init = 26'd0;
    new_image();
    send(0, 0, 1'b1, 1'b1);
    finish_image("B");
    check(got_n == 1 && got_b[0] == 8'h80, "R9 aligned pad byte", got_b[0], 8'h80);

    // image C: escape codeword
    c_g0 = 4'd8; c_g = 4'd9; c_d = 5'd16; c_umax = 6'd8; c_init = 26'd5120;
    new_image();
    bp_on = 1'b1;
    send(1000, 3, 1'b1, 1'b0);
    finish_image("C");
    bp_on = 1'b0;
    check(got_n == 4 && got_b[0] == 8'h03 && got_b[1] == 8'hE8 && got_b[2] == 8'h00
          && got_b[3] == 8'h80, "R7 escape bytes", {got_b[0], got_b[1]}, 16'h03E8);

    // image D: plain codeword, k = 4
    c_g0 = 4'd1; c_g = 4'd4; c_d = 5'd8; c_init = 26'd60;
    new_image();
    send(10, 2, 1'b1, 1'b0);
    finish_image("D");
    check(got_n == 1 && got_b[0] == 8'hAC, "R6 codeword byte", got_b[0], 8'hAC);

    // image E: halving on a low-entropy sample emits only the sum's low bit
    c_g0 = 4'd3; c_g = 4'd4; c_init = 26'd0;
    new_image();
    for (int i = 0; i < 7; i++) send(0, 1, 1'b0, 1'b0);
    send(5, 1, 1'b1, 1'b0);
    finish_image("E");
    check(got_n == 1 && got_b[0] == 8'hC0, "R3 halving bit", got_b[0], 8'hC0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule